// File: doc/BRIEF.md
# Scanline Dot Timing Generator

This block is the position engine of a handheld-console LCD controller. On every dot-clock enable it advances a dot counter within the scanline and a line counter within the frame. From the new position it derives a two-bit display mode: H-Blank, V-Blank, OAM Scan or Pixel Transfer. On the tick where a transition happens it raises one-cycle pulses for a mode change, the start of H-Blank (the current line may be rendered), the start of vertical blank and the start of a new frame. It also sets a frame-ready flag that stays high until software clears it.

Switching the LCD on loads a fixed preset. The first line starts part-way in, at dot 4. For its opening dots it reports H-Blank rather than OAM Scan, and it then moves straight to Pixel Transfer. A status output marks that line so that downstream interrupt logic can suppress mode interrupts. A registered compare flags when the current line matches a software-supplied line number.

Top module: `lcd_dot_timer`

## Requirements
- R1: While `rst_n` is low, or on the clock after any edge where `lcd_on` is low, `dot_idx`, `line_idx`, `mode` and `first_line` are 0 and no event pulse is high. Reset also clears `frame_ready`.
- R2: On the first edge with `lcd_on` high after it was low (or after reset), the block loads `dot_idx`=4, `line_idx`=0, `mode`=0 (H-Blank) and `first_line`=1. This edge is not a tick and raises no event.
- R3: Every later edge with `lcd_on` and `dot_en` high is a tick. A tick increments `dot_idx`. The value 456 becomes 0 and increments `line_idx`, and the line index wraps from 153 to 0.
- R4: An edge with `lcd_on` high, the preset already loaded and `dot_en` low changes neither the dot, line, mode nor first-line outputs, and it raises no event pulse.
- R5: Mode codes are 0=H-Blank, 1=V-Blank, 2=OAM Scan, 3=Pixel Transfer. On lines 0–143, outside the first line, dots 0–79 give 2, dots 80–251 give 3 and dots 252–455 give 0.
- R6: Lines 144–153 give mode 1 for every dot.
- R7: While `first_line` is set, dots below 80 give mode 0 and dot 80 gives mode 3 directly. `first_line` clears on the tick where the line leaves 0, so that line lasts 452 ticks.
- R8: `ev_mode_chg` is high for one cycle after a tick whose new mode differs from the mode before it.
- R9: `ev_render` pulses with a mode change into 0, and `ev_vblank` pulses with a mode change into 1.
- R10: `ev_frame` pulses after the tick that wraps line 153 to line 0, and that same tick sets `frame_ready`. `frame_ready` is cleared only by `ready_clr`, and a set on the same edge takes priority over the clear.
- R11: `ly_match` is registered. It shows whether `line_idx` equalled `lyc` at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_on | input | 1 | LCD enable; low holds idle, rising loads preset |
| dot_en | input | 1 | Dot tick enable |
| ready_clr | input | 1 | Clears the frame-ready flag |
| lyc | input | 8 | Line number to compare against |
| line_idx | output | 8 | Current line 0–153 |
| dot_idx | output | 9 | Current dot 0–455 |
| mode | output | 2 | Display mode code |
| first_line | output | 1 | High during the first line after enable |
| frame_ready | output | 1 | Sticky frame-complete flag |
| ev_mode_chg | output | 1 | Mode-change pulse |
| ev_render | output | 1 | H-Blank entry pulse |
| ev_vblank | output | 1 | V-Blank entry pulse |
| ev_frame | output | 1 | New-frame pulse |
| ly_match | output | 1 | Registered line compare |

## Verification
Every output is a register, so each result of an edge is due one clock after the inputs that caused it. The bench drives inputs, waits for the edge, then samples 1 ns after it. The compare output lags the line index by one further edge, so the bench checks it against the line it expected before that edge. Expected positions come arithmetically from the tick count (offset by the preset dot) across more than a full frame, including gapped `dot_en` patterns and a re-enable.

// File: rtl/lcd_dot_timer.sv
module lcd_dot_timer #(
  parameter int DOTS_PER_LINE = 456,
  parameter int LINE_COUNT    = 154,
  parameter int VBLANK_LINE   = 144,
  parameter int SCAN_DOTS     = 80,
  parameter int XFER_DOTS     = 172,
  parameter int START_DOT     = 4,
  parameter int LINE_W        = 8,
  parameter int DOT_W         = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic              dot_en,
  input  logic              ready_clr,
  input  logic [LINE_W-1:0] lyc,
  output logic [LINE_W-1:0] line_idx,
  output logic [DOT_W-1:0]  dot_idx,
  output logic [1:0]        mode,
  output logic              first_line,
  output logic              frame_ready,
  output logic              ev_mode_chg,
  output logic              ev_render,
  output logic              ev_vblank,
  output logic              ev_frame,
  output logic              ly_match
);
  localparam int XFER_END = SCAN_DOTS + XFER_DOTS;
  localparam logic [1:0] M_HBL = 2'd0, M_VBL = 2'd1, M_SCAN = 2'd2, M_XFER = 2'd3;

  logic              armed;
  logic [DOT_W-1:0]  dot_inc, nxt_dot;
  logic [LINE_W-1:0] nxt_line;
  logic              dot_wrap, last_line, frame_wrap, tick;
  logic [1:0]        nxt_mode;

  assign tick       = lcd_on && armed && dot_en;
  assign dot_inc    = dot_idx + 1'b1;
  assign dot_wrap   = dot_inc == DOT_W'(DOTS_PER_LINE);
  assign last_line  = line_idx == LINE_W'(LINE_COUNT - 1);
  assign frame_wrap = dot_wrap && last_line;
  assign nxt_dot    = dot_wrap ? '0 : dot_inc;
  assign nxt_line   = !dot_wrap ? line_idx : (last_line ? '0 : line_idx + 1'b1);

  always_comb begin
    if (nxt_line >= LINE_W'(VBLANK_LINE))       nxt_mode = M_VBL;
    else if (nxt_dot < DOT_W'(SCAN_DOTS))       nxt_mode = (first_line && nxt_line == '0) ? M_HBL : M_SCAN;
    else if (nxt_dot < DOT_W'(XFER_END))        nxt_mode = M_XFER;
    else                                        nxt_mode = M_HBL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      dot_idx     <= '0;
      line_idx    <= '0;
      mode        <= M_HBL;
      first_line  <= 1'b0;
      frame_ready <= 1'b0;
      ev_mode_chg <= 1'b0;
      ev_render   <= 1'b0;
      ev_vblank   <= 1'b0;
      ev_frame    <= 1'b0;
      ly_match    <= 1'b0;
    end else begin
      ly_match    <= line_idx == lyc;
      ev_mode_chg <= 1'b0;
      ev_render   <= 1'b0;
      ev_vblank   <= 1'b0;
      ev_frame    <= 1'b0;
      if (!lcd_on) begin
        armed      <= 1'b0;
        dot_idx    <= '0;
        line_idx   <= '0;
        mode       <= M_HBL;
        first_line <= 1'b0;
      end else if (!armed) begin
        armed      <= 1'b1;
        dot_idx    <= DOT_W'(START_DOT);
        line_idx   <= '0;
        mode       <= M_HBL;
        first_line <= 1'b1;
      end else if (dot_en) begin
        dot_idx     <= nxt_dot;
        line_idx    <= nxt_line;
        mode        <= nxt_mode;
        ev_mode_chg <= nxt_mode != mode;
        ev_render   <= nxt_mode != mode && nxt_mode == M_HBL;
        ev_vblank   <= nxt_mode != mode && nxt_mode == M_VBL;
        ev_frame    <= frame_wrap;
        if (nxt_line != '0) first_line <= 1'b0;
      end
      if (tick && frame_wrap) frame_ready <= 1'b1;
      else if (ready_clr)     frame_ready <= 1'b0;
    end
  end

  AST_IDLE_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> (dot_idx == '0 && line_idx == '0 && !first_line && !ev_mode_chg)); // R1
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && !armed) |=> (dot_idx == DOT_W'(START_DOT) && first_line && mode == M_HBL)); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_idx < DOT_W'(DOTS_PER_LINE) && line_idx < LINE_W'(LINE_COUNT)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && armed && !dot_en) |=> ($stable(dot_idx) && $stable(line_idx) && $stable(mode) && !ev_mode_chg)); // R4
  AST_VBL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx >= LINE_W'(VBLANK_LINE) |-> mode == M_VBL); // R6
  AST_FIRST_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    first_line |-> (line_idx == '0 && mode != M_SCAN)); // R7
  AST_RENDER_HBL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_render || ev_vblank) |-> (ev_mode_chg && (ev_render ? mode == M_HBL : mode == M_VBL))); // R9
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> (line_idx == '0 && dot_idx == '0 && frame_ready)); // R10
endmodule

// File: tb/lcd_dot_timer_tb_top.sv
`timescale 1ns/100ps
module lcd_dot_timer_tb_top;
  localparam int DPL = 456, FRAME = 456 * 154;

  logic clk = 1'b0, rst_n = 1'b0, lcd_on = 1'b0, dot_en = 1'b0, ready_clr = 1'b0;
  logic [7:0] lyc = 8'd5;
  logic [7:0] line_idx;
  logic [8:0] dot_idx;
  logic [1:0] mode;
  logic first_line, frame_ready, ev_mode_chg, ev_render, ev_vblank, ev_frame, ly_match;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  bit m_armed = 1'b0;
  int m_p = 0;
  bit m_fr = 1'b0;
  int m_line = 0, m_dot = 0, m_mode = 0, m_first = 0;

  always #2.5 clk = ~clk;

  lcd_dot_timer dut_i (.clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .dot_en(dot_en),
    .ready_clr(ready_clr), .lyc(lyc), .line_idx(line_idx), .dot_idx(dot_idx), .mode(mode),
    .first_line(first_line), .frame_ready(frame_ready), .ev_mode_chg(ev_mode_chg),
    .ev_render(ev_render), .ev_vblank(ev_vblank), .ev_frame(ev_frame), .ly_match(ly_match));

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      if (fails < 30) $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mode_of(input int p);
    int line = (p % FRAME) / DPL;
    int dot  = p % DPL;
    if (line >= 144) return 1;
    if (dot < 80) return (p < DPL) ? 0 : 2;
    if (dot < 252) return 3;
    return 0;
  endfunction

  task automatic step(input bit on, input bit en, input bit clr, input logic [7:0] ly);
    int old_line = m_line, old_mode = m_mode;
    bit tk = 1'b0, preset = 1'b0, fwrap = 1'b0;
    string tg;
    lcd_on = on; dot_en = en; ready_clr = clr; lyc = ly;
    @(posedge clk); #1;
    if (!on) begin
      m_armed = 1'b0; m_p = 0; m_line = 0; m_dot = 0; m_mode = 0; m_first = 0;
    end else if (!m_armed) begin
      m_armed = 1'b1; preset = 1'b1; m_p = 4;
    end else if (en) begin
      tk = 1'b1; m_p++;
      fwrap = (m_p % FRAME) == 0;
    end
    if (on) begin
      m_line = (m_p % FRAME) / DPL; m_dot = m_p % DPL;
      m_mode = mode_of(m_p); m_first = (m_p < DPL) ? 1 : 0;
    end
    if (tk && fwrap) m_fr = 1'b1; else if (clr) m_fr = 1'b0;
    tg = !on ? "R1" : preset ? "R2" : !en ? "R4" : "";
    chk(tg == "" ? "R3" : tg, "dot", dot_idx, m_dot);
    chk(tg == "" ? "R3" : tg, "line", line_idx, m_line);
    chk(tg != "" ? tg : m_line >= 144 ? "R6" : m_first != 0 ? "R7" : "R5", "mode", mode, m_mode);
    chk(tg == "" ? "R7" : tg, "first_line", first_line, m_first);
    chk(tg == "" ? "R8" : tg, "ev_mode_chg", ev_mode_chg, int'(tk && m_mode != old_mode));
    chk(tg == "" ? "R9" : tg, "ev_render", ev_render, int'(tk && m_mode != old_mode && m_mode == 0));
    chk(tg == "" ? "R9" : tg, "ev_vblank", ev_vblank, int'(tk && m_mode != old_mode && m_mode == 1));
    chk(tg == "" ? "R10" : tg, "ev_frame", ev_frame, int'(tk && fwrap));
    chk("R10", "frame_ready", frame_ready, int'(m_fr));
    chk("R11", "ly_match", ly_match, int'(old_line == int'(ly)));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    while (!done) begin
      @(posedge clk);
      if (!done && $time > 64'd950000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "reset dot", dot_idx, 0);
    chk("R1", "reset line", line_idx, 0);
    chk("R1", "reset mode", mode, 0);
    chk("R1", "reset frame_ready", frame_ready, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 8'd0);
    step(1'b1, 1'b0, 1'b0, 8'd0);                       // R2 preset
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 8'd0); // R4 hold
    // full frame plus one line, steady ticks, lyc on a mid line
    for (int i = 0; i < FRAME + 600; i++) step(1'b1, 1'b1, 1'b0, 8'd5);
    // gapped ticks across several lines, sweeping lyc
    for (int i = 0; i < 3000; i++) step(1'b1, (i % 3) != 0, 1'b0, 8'(i / 400));
    step(1'b1, 1'b0, 1'b1, 8'd0);                       // R10 clear
    step(1'b0, 1'b0, 1'b0, 8'd0);                       // R1 off
    step(1'b0, 1'b1, 1'b0, 8'd0);
    step(1'b1, 1'b1, 1'b0, 8'd0);                       // R2 re-enable
    for (int i = 0; i < 1000; i++) step(1'b1, 1'b1, 1'b0, 8'd1); // R7 first line again
    // run to vblank start and to the next wrap with clear held: set must win
    while (m_p % FRAME != FRAME - 1) step(1'b1, 1'b1, 1'b0, 8'd153);
    step(1'b1, 1'b1, 1'b1, 8'd0);                       // R10 set beats clear
    step(1'b1, 1'b1, 1'b1, 8'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule